// File: doc/BRIEF.md
# Dirty Row-Band Update Coalescer

This block walks a per-band dirty bitmap once per frame, from the top of the display to the bottom. Each bitmap bit stands for a band of four display lines. Consecutive dirty bands are merged into full-width update rectangles. Each rectangle is reported as a start row and a height, on a valid/ready output. The bitmap itself lives outside the block. The block presents a band index, and the neighbouring logic answers with that band's dirty bit in the same cycle.

While it scans, the block keeps the lowest and highest dirty band index. Once every rectangle of the frame has been accepted, it issues at most one clear command that covers that inclusive band range, so that the owner of the bitmap can reset it. It then pulses a done flag for one cycle. When the output surface is switched off, a start request skips the scan entirely and only produces the done pulse.

A scan begins with a one-cycle start pulse that samples the active display height in rows. The rectangle output holds one entry. The walk pauses whenever that entry has not yet been taken, so no rectangle is ever dropped.

Top module: `band_update_coalescer`

## Requirements
- R1: After reset, rect_valid_o, clr_valid_o and done_o are all low.
- R2: The scan visits band indices 0, 1, 2, ... on band_idx_o, where band k covers rows 4k to 4k+3. Bands whose first row is at or beyond the sampled height are not visited. Every rectangle has a start row and a height that are multiples of four, and its height is never zero.
- R3: A dirty band met while no run is open opens a run whose start row is 4 times that band's index.
- R4: A clean band met while a run is open emits a rectangle. Its start row is the run's start row, and its height is the clean band's first row minus the start row. The run then closes.
- R5: If a run is still open when the scan ends, a final rectangle is emitted. Its height is the first multiple of four at or above the display height, minus the start row. A height of zero visits no band.
- R6: After the scan, clr_valid_o is high for exactly one cycle, with clr_first_o and clr_last_o equal to the lowest and highest dirty band indices of the frame. If no visited band was dirty, no clear is issued.
- R7: A start pulse while surface_off_i is high produces no rectangle and no clear, and done_o rises in the following cycle.
- R8: While rect_valid_o is high and rect_ready_i is low, rect_valid_o stays high and rect_row_o and rect_height_o hold their values.
- R9: Every rectangle of a frame is accepted before its clear. done_o is high for exactly one cycle, in the cycle after the clear, or in the cycle after the skipped clear would have been issued.
- R10: A start pulse that arrives while a scan is in progress is ignored. The frame's rectangles and clear range are unchanged by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to scan a frame |
| surface_off_i | input | 1 | Output surface disabled; skip the scan |
| height_i | input | ROW_W | Active display height in rows, sampled at start |
| band_idx_o | output | ROW_W-2 | Band whose dirty bit is being looked up |
| band_dirty_i | input | 1 | Dirty bit of band band_idx_o, same cycle |
| rect_valid_o | output | 1 | A rectangle is offered |
| rect_ready_i | input | 1 | Consumer takes the offered rectangle |
| rect_row_o | output | ROW_W | First row of the rectangle |
| rect_height_o | output | ROW_W+1 | Height of the rectangle in rows (width is always the full display) |
| clr_valid_o | output | 1 | One-cycle clear command for a band range |
| clr_first_o | output | ROW_W-2 | Lowest dirty band index |
| clr_last_o | output | ROW_W-2 | Highest dirty band index |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
A wrong run-open flag or run start row shows up at the ports as a rectangle with a wrong start row or height, or as two rectangles where there should be one. The error appears at the first clean band, or at the end of the frame, after the faulty band. A corrupted minimum or maximum stays hidden until the clear command at the end of the frame, so frames are chosen with dirty bands at both edges, isolated bands and runs that reach the height limit. Stalls from a slow consumer are mixed in to expose payload changes and scan progress while a rectangle is pending.

// File: rtl/band_coalesce_pkg.sv
package band_coalesce_pkg;

    localparam int LINES_PER_BAND = 4;
    localparam int BAND_SHIFT     = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_FLUSH,
        ST_CLEAR,
        ST_DONE
    } scan_state_e;

    // True when a row value lies on a band boundary.
    function automatic logic band_aligned(input logic [1:0] low_bits);
        return low_bits == 2'b00;
    endfunction

endpackage

// File: rtl/band_range_tracker.sv
module band_range_tracker #(
    parameter int BAND_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              hit_i,
    input  logic [BAND_W-1:0] band_i,
    output logic              any_o,
    output logic [BAND_W-1:0] lo_o,
    output logic [BAND_W-1:0] hi_o
);

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            any_o <= 1'b0;
            lo_o  <= '0;
            hi_o  <= '0;
        end else if (hit_i) begin
            any_o <= 1'b1;
            if (!any_o || band_i < lo_o) lo_o <= band_i;
            if (!any_o || band_i > hi_o) hi_o <= band_i;
        end
    end

    // R6: the tracked range is ordered once any band was recorded
    a_r6_range_ordered: assert property (@(posedge clk) disable iff (rst)
        any_o |-> (lo_o <= hi_o));

    // R6: a recorded band lies inside the range in the next cycle
    a_r6_hit_covered: assert property (@(posedge clk) disable iff (rst)
        (hit_i && !clear_i) |=> (any_o && lo_o <= $past(band_i) && hi_o >= $past(band_i)));

endmodule

// File: rtl/band_rect_emitter.sv
module band_rect_emitter #(
    parameter type payload_t = logic [7:0]
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     load_i,
    input  payload_t payload_i,
    output logic     full_o,
    output logic     valid_o,
    input  logic     ready_i,
    output payload_t payload_o
);

    payload_t hold_q;
    logic     full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            hold_q <= '0;
        end else if (load_i && !full_q) begin
            full_q <= 1'b1;
            hold_q <= payload_i;
        end else if (full_q && ready_i) begin
            full_q <= 1'b0;
        end
    end

    assign full_o    = full_q;
    assign valid_o   = full_q;
    assign payload_o = hold_q;

    // R8: an offered rectangle stays offered and unchanged until taken
    a_r8_hold_payload: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !ready_i) |=> (valid_o && $stable(payload_o)));

endmodule

// File: rtl/band_update_coalescer.sv
module band_update_coalescer
    import band_coalesce_pkg::*;
#(
    parameter int ROW_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               surface_off_i,
    input  logic [ROW_W-1:0]   height_i,
    output logic [ROW_W-3:0]   band_idx_o,
    input  logic               band_dirty_i,
    output logic               rect_valid_o,
    input  logic               rect_ready_i,
    output logic [ROW_W-1:0]   rect_row_o,
    output logic [ROW_W:0]     rect_height_o,
    output logic               clr_valid_o,
    output logic [ROW_W-3:0]   clr_first_o,
    output logic [ROW_W-3:0]   clr_last_o,
    output logic               done_o
);

    localparam int HGT_W  = ROW_W + 1;
    localparam int BAND_W = ROW_W - BAND_SHIFT;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [HGT_W-1:0] height;
    } rect_t;

    scan_state_e      state_q;
    logic [HGT_W-1:0] row_q;
    logic [ROW_W-1:0] limit_q;
    logic [ROW_W-1:0] run_start_q;
    logic             run_open_q;

    logic             at_end, step, band_hit, close_run, final_emit, load;
    logic             emit_full, range_any, track_clear;
    rect_t            rect_in, rect_out;

    assign at_end     = row_q >= {1'b0, limit_q};
    assign step       = (state_q == ST_SCAN) && !at_end && !emit_full;
    assign band_hit   = step && band_dirty_i;
    assign close_run  = step && !band_dirty_i && run_open_q;
    assign final_emit = (state_q == ST_FLUSH) && !emit_full;
    assign load       = close_run || final_emit;
    assign track_clear = (state_q == ST_IDLE) && start_i && !surface_off_i;

    assign rect_in.row    = run_start_q;
    assign rect_in.height = row_q - {1'b0, run_start_q};

    assign band_idx_o = row_q[ROW_W-1:BAND_SHIFT];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            row_q       <= '0;
            limit_q     <= '0;
            run_start_q <= '0;
            run_open_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (surface_off_i) begin
                            state_q <= ST_DONE;
                        end else begin
                            state_q    <= ST_SCAN;
                            limit_q    <= height_i;
                            row_q      <= '0;
                            run_open_q <= 1'b0;
                        end
                    end
                end
                ST_SCAN: begin
                    if (at_end) begin
                        state_q <= run_open_q ? ST_FLUSH : ST_CLEAR;
                    end else if (step) begin
                        row_q <= row_q + HGT_W'(LINES_PER_BAND);
                        if (band_hit && !run_open_q) begin
                            run_open_q  <= 1'b1;
                            run_start_q <= row_q[ROW_W-1:0];
                        end
                        if (close_run) run_open_q <= 1'b0;
                    end
                end
                ST_FLUSH: begin
                    if (!emit_full) begin
                        run_open_q <= 1'b0;
                        state_q    <= ST_CLEAR;
                    end
                end
                ST_CLEAR: begin
                    if (!emit_full) state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    band_rect_emitter #(.payload_t(rect_t)) u_emit (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load),
        .payload_i (rect_in),
        .full_o    (emit_full),
        .valid_o   (rect_valid_o),
        .ready_i   (rect_ready_i),
        .payload_o (rect_out)
    );

    band_range_tracker #(.BAND_W(BAND_W)) u_range (
        .clk     (clk),
        .rst     (rst),
        .clear_i (track_clear),
        .hit_i   (band_hit),
        .band_i  (band_idx_o),
        .any_o   (range_any),
        .lo_o    (clr_first_o),
        .hi_o    (clr_last_o)
    );

    assign rect_row_o    = rect_out.row;
    assign rect_height_o = rect_out.height;
    assign clr_valid_o   = (state_q == ST_CLEAR) && !emit_full && range_any;
    assign done_o        = (state_q == ST_DONE);

    // R2: rectangles are band aligned and never empty
    a_r2_band_aligned: assert property (@(posedge clk) disable iff (rst)
        rect_valid_o |-> (band_aligned(rect_row_o[1:0]) &&
                          band_aligned(rect_height_o[1:0]) && rect_height_o != '0));

    // R9: a clear is followed by done in the next cycle
    a_r9_done_after_clear: assert property (@(posedge clk) disable iff (rst)
        clr_valid_o |=> done_o);

    // R9: done lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9: the clear never overlaps a pending rectangle
    a_r9_clear_after_rects: assert property (@(posedge clk) disable iff (rst)
        clr_valid_o |-> !rect_valid_o);

    // R6: the clear command is a single-cycle pulse
    a_r6_clear_single: assert property (@(posedge clk) disable iff (rst)
        clr_valid_o |=> !clr_valid_o);

    // R7: a skipped frame finishes in the next cycle with nothing emitted
    a_r7_skip_done: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && start_i && surface_off_i) |=> (done_o && !rect_valid_o && !clr_valid_o));

endmodule

// File: tb/band_update_coalescer_tb_top.sv
module band_update_coalescer_tb_top;

    localparam int ROW_W = 12;

    typedef struct packed {
        logic [15:0] map;
        logic [11:0] hgt;
        logic [4:0]  nrect;
    } vec_t;

    // stimulus bitmap (bit k = band k), height, expected rectangle count
    localparam vec_t VECS [9] = '{
        '{16'h0000, 12'd64, 5'd0},
        '{16'h0001, 12'd64, 5'd1},
        '{16'h8000, 12'd64, 5'd1},
        '{16'h0F0F, 12'd64, 5'd2},
        '{16'hAAAA, 12'd64, 5'd8},
        '{16'hFFFF, 12'd64, 5'd1},
        '{16'hFFFF, 12'd30, 5'd1},
        '{16'h0180, 12'd32, 5'd1},
        '{16'h0FF0, 12'd0,  5'd0}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             surf_off = 1'b0;
    logic [ROW_W-1:0] height = '0;
    logic [ROW_W-3:0] band_idx;
    logic             band_dirty;
    logic             rect_valid;
    logic             rect_ready = 1'b1;
    logic [ROW_W-1:0] rect_row;
    logic [ROW_W:0]   rect_hgt;
    logic             clr_valid;
    logic [ROW_W-3:0] clr_first, clr_last;
    logic             done;

    logic [15:0]      cur_map = '0;
    int               ready_mode = 0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int cap_n = 0;
    int cap_row [32];
    int cap_hgt [32];
    int clr_n = 0;
    int clr_lo_cap = 0, clr_hi_cap = 0, clr_cyc = -10;
    int done_n = 0, done_cyc = -10;
    logic prev_valid = 1'b0, prev_ready = 1'b0, prev_done = 1'b0;
    logic [ROW_W-1:0] prev_row = '0;
    logic [ROW_W:0]   prev_hgt = '0;

    int exp_n;
    int exp_row [32];
    int exp_hgt [32];
    int exp_lo, exp_hi;
    logic exp_any;

    always #2 clk = ~clk;

    assign band_dirty = (band_idx < 16) ? cur_map[band_idx[3:0]] : 1'b0;

    band_update_coalescer #(.ROW_W(ROW_W)) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .surface_off_i(surf_off),
        .height_i(height), .band_idx_o(band_idx), .band_dirty_i(band_dirty),
        .rect_valid_o(rect_valid), .rect_ready_i(rect_ready),
        .rect_row_o(rect_row), .rect_height_o(rect_hgt),
        .clr_valid_o(clr_valid), .clr_first_o(clr_first), .clr_last_o(clr_last),
        .done_o(done)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor and consumer: decide ready first, then sample the transfer
    always @(negedge clk) begin
        cyc++;
        rect_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
        if (!rst) begin
            if (prev_valid && !prev_ready) begin
                checks++;
                if (!rect_valid || rect_row != prev_row || rect_hgt != prev_hgt) begin
                    errors++;
                    $display("FAIL R8 stall hold actual=%0d/%0d expected=%0d/%0d",
                             rect_row, rect_hgt, prev_row, prev_hgt);
                end
            end
            if (rect_valid && rect_ready && cap_n < 32) begin
                cap_row[cap_n] = int'(rect_row);
                cap_hgt[cap_n] = int'(rect_hgt);
                cap_n++;
            end
            if (clr_valid) begin
                clr_n++;
                clr_lo_cap = int'(clr_first);
                clr_hi_cap = int'(clr_last);
                clr_cyc = cyc;
                chk(!rect_valid, "R9 clear with pending rect", 1, 0);
            end
            if (done) begin
                done_n++;
                done_cyc = cyc;
            end
            if (prev_done) chk(!done, "R9 done width", int'(done), 0);
        end
        prev_valid = rect_valid;
        prev_ready = rect_ready;
        prev_row   = rect_row;
        prev_hgt   = rect_hgt;
        prev_done  = done;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic model(input logic [15:0] map, input int hgt);
        int b = 0;
        int st = -1;
        exp_n = 0; exp_any = 1'b0; exp_lo = 0; exp_hi = 0;
        while (b * 4 < hgt) begin
            if (b < 16 && map[b]) begin
                if (st < 0) st = b * 4;
                if (!exp_any) begin exp_lo = b; exp_hi = b; end
                else begin
                    if (b < exp_lo) exp_lo = b;
                    if (b > exp_hi) exp_hi = b;
                end
                exp_any = 1'b1;
            end else if (st >= 0) begin
                exp_row[exp_n] = st; exp_hgt[exp_n] = b * 4 - st; exp_n++;
                st = -1;
            end
            b++;
        end
        if (st >= 0) begin
            exp_row[exp_n] = st; exp_hgt[exp_n] = b * 4 - st; exp_n++;
        end
    endtask

    task automatic run_frame(input logic [15:0] map, input int hgt, input logic off,
                             input int mode, input int restart_at);
        int k = 0;
        cur_map = map; ready_mode = mode;
        cap_n = 0; clr_n = 0; done_n = 0; clr_cyc = -10; done_cyc = -10;
        @(negedge clk);
        surf_off = off; height = ROW_W'(hgt); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (done_n == 0 && k < 3000) begin
            k++;
            if (k == restart_at) begin height = 12'd8; start = 1'b1; end
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        chk(done_n == 1, "R9 done pulse count", done_n, 1);
        repeat (3) @(negedge clk);
    endtask

    task automatic compare(input string tag);
        chk(cap_n == exp_n, {tag, " R4 R5 rect count"}, cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            chk(cap_row[i] == exp_row[i], {tag, " R3 rect row"}, cap_row[i], exp_row[i]);
            chk(cap_hgt[i] == exp_hgt[i], {tag, " R4 R5 rect height"}, cap_hgt[i], exp_hgt[i]);
        end
        chk(clr_n == (exp_any ? 1 : 0), {tag, " R6 clear count"}, clr_n, exp_any ? 1 : 0);
        if (exp_any && clr_n == 1) begin
            chk(clr_lo_cap == exp_lo, {tag, " R6 clear first"}, clr_lo_cap, exp_lo);
            chk(clr_hi_cap == exp_hi, {tag, " R6 clear last"}, clr_hi_cap, exp_hi);
            chk(done_cyc == clr_cyc + 1, {tag, " R9 done after clear"}, done_cyc, clr_cyc + 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!rect_valid, "R1 rect_valid after reset", int'(rect_valid), 0);
        chk(!clr_valid, "R1 clr_valid after reset", int'(clr_valid), 0);
        chk(!done, "R1 done after reset", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);

        // table walk, alternating fast and slow consumer
        foreach (VECS[i]) begin
            model(VECS[i].map, int'(VECS[i].hgt));
            chk(exp_n == int'(VECS[i].nrect), "R2 table expectation", exp_n, int'(VECS[i].nrect));
            run_frame(VECS[i].map, int'(VECS[i].hgt), 1'b0, i % 2, 0);
            compare($sformatf("vec%0d", i));
        end

        // R7: surface disabled skips the scan
        run_frame(16'hFFFF, 64, 1'b1, 0, 0);
        chk(cap_n == 0, "R7 no rect when off", cap_n, 0);
        chk(clr_n == 0, "R7 no clear when off", clr_n, 0);

        // R10: start during a scan is ignored
        model(16'h0F0F, 64);
        run_frame(16'h0F0F, 64, 1'b0, 1, 6);
        compare("R10 restart ignored");

        // R8 under heavy stall with many isolated runs
        model(16'h5555, 64);
        run_frame(16'h5555, 64, 1'b0, 1, 0);
        compare("R8 stall frame");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule